// File: doc/BRIEF.md
# Accumulator Adder and Logic Unit

This block holds a 16-bit accumulator and a one-bit extend flag, together with the logic that computes their next values. Each clock, an external control decoder asserts at most one line of a one-hot operation vector. The selected operation updates the accumulator, the extend flag, or both, on the next rising clock edge.

The accumulator operations are bitwise AND with a data operand, add with carry-out, load from the operand, load of the low byte only from an 8-bit input character, complement, clear, increment, and rotate left or right through the extend flag. Two further operations act on the extend flag alone: clear it or invert it. The accumulator value drives the shared bus. Two flags are derived from it without a register stage: one shows that the accumulator is zero, the other gives its top bit (the sign). Skip logic elsewhere uses these flags.

Top module: `acc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator and the extend flag both become 0.
- R2: With `op_sel` bit 0 set, the accumulator becomes the bitwise AND of itself and `dr_in`. The extend flag is unchanged.
- R3: With `op_sel` bit 1 set, the accumulator becomes its sum with `dr_in` modulo 2^16. The extend flag takes the carry out of bit 15.
- R4: With `op_sel` bit 2 set, the accumulator is loaded from `dr_in`. The extend flag is unchanged.
- R5: With `op_sel` bit 3 set, accumulator bits 7..0 take `inp_in`. Bits 15..8 and the extend flag are unchanged.
- R6: With `op_sel` bit 4 set, every accumulator bit is inverted. With bit 7 set, the accumulator becomes 0. In both cases the extend flag is unchanged.
- R7: With `op_sel` bit 8 set, the accumulator increments by 1 and wraps from 0xFFFF to 0x0000. The extend flag is unchanged.
- R8: With `op_sel` bit 5 set, the accumulator shifts right by one bit. Bit 15 takes the old extend flag, and the extend flag takes the old bit 0.
- R9: With `op_sel` bit 6 set, the accumulator shifts left by one bit. Bit 0 takes the old extend flag, and the extend flag takes the old bit 15.
- R10: With `op_sel` bit 9 set, the extend flag becomes 0. With bit 10 set, the extend flag is inverted. In both cases the accumulator is unchanged.
- R11: With `op_sel` all zero, the accumulator and the extend flag hold their values.
- R12: `acc_zero` is 1 exactly when the accumulator is 0, and `acc_sign` equals accumulator bit 15, both without a register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 11 | One-hot operation select; bit positions as listed in R2 to R10 |
| dr_in | input | 16 | Data operand |
| inp_in | input | 8 | Input character for the low-byte load |
| acc_out | output | 16 | Accumulator value |
| e_out | output | 1 | Extend flag |
| acc_zero | output | 1 | Accumulator-is-zero flag |
| acc_sign | output | 1 | Accumulator bit 15 |

## Verification
The bound checker checks the following on every cycle:
- the AND, add-with-carry, rotate, low-byte load and hold results against the previous cycle's operands;
- that the extend flag stays stable under every operation that must not touch it;
- that the two flags match the accumulator value;
- that the select vector is one-hot or zero.

Only the bench scenarios exercise the following:
- the reset values;
- wrap-around on increment and on an add that carries out of all sixteen bits;
- chains of rotations that move the extend bit through the whole word;
- long random mixes of operations, compared against a model kept in the bench.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int ACC_W  = 16;
    localparam int CHAR_W = 8;
    localparam int N_OPS  = 11;

    localparam int OP_AND  = 0;
    localparam int OP_ADD  = 1;
    localparam int OP_XFER = 2;
    localparam int OP_INP  = 3;
    localparam int OP_CMP  = 4;
    localparam int OP_SHR  = 5;
    localparam int OP_SHL  = 6;
    localparam int OP_CLR  = 7;
    localparam int OP_INC  = 8;
    localparam int OP_ECL  = 9;
    localparam int OP_ECM  = 10;

    typedef struct packed {
        logic do_and;
        logic do_add;
        logic do_xfer;
        logic do_inp;
        logic do_cmp;
        logic do_shr;
        logic do_shl;
        logic do_clr;
        logic do_inc;
        logic do_ecl;
        logic do_ecm;
    } acc_op_t;

    function automatic acc_op_t decode_op(input logic [N_OPS-1:0] sel);
        acc_op_t o;
        o.do_and  = sel[OP_AND];
        o.do_add  = sel[OP_ADD];
        o.do_xfer = sel[OP_XFER];
        o.do_inp  = sel[OP_INP];
        o.do_cmp  = sel[OP_CMP];
        o.do_shr  = sel[OP_SHR];
        o.do_shl  = sel[OP_SHL];
        o.do_clr  = sel[OP_CLR];
        o.do_inc  = sel[OP_INC];
        o.do_ecl  = sel[OP_ECL];
        o.do_ecm  = sel[OP_ECM];
        return o;
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W    = ACC_W,
    parameter int IN_W = CHAR_W
) (
    input  acc_op_t         op,
    input  logic [W-1:0]    ac,
    input  logic            e,
    input  logic [W-1:0]    dr,
    input  logic [IN_W-1:0] inp,
    output logic [W-1:0]    ac_nxt,
    output logic            e_nxt,
    output logic            ac_ld,
    output logic            e_ld
);

    logic [W:0] sum;
    logic [W:0] incr;

    assign sum  = {1'b0, ac} + {1'b0, dr};
    assign incr = {1'b0, ac} + {{W{1'b0}}, 1'b1};

    always_comb begin
        ac_nxt = ac;
        e_nxt  = e;
        ac_ld  = 1'b0;
        e_ld   = 1'b0;
        if (op.do_and) begin
            ac_nxt = ac & dr;
            ac_ld  = 1'b1;
        end else if (op.do_add) begin
            ac_nxt = sum[W-1:0];
            e_nxt  = sum[W];
            ac_ld  = 1'b1;
            e_ld   = 1'b1;
        end else if (op.do_xfer) begin
            ac_nxt = dr;
            ac_ld  = 1'b1;
        end else if (op.do_inp) begin
            ac_nxt = {ac[W-1:IN_W], inp};
            ac_ld  = 1'b1;
        end else if (op.do_cmp) begin
            ac_nxt = ~ac;
            ac_ld  = 1'b1;
        end else if (op.do_shr) begin
            ac_nxt = {e, ac[W-1:1]};
            e_nxt  = ac[0];
            ac_ld  = 1'b1;
            e_ld   = 1'b1;
        end else if (op.do_shl) begin
            ac_nxt = {ac[W-2:0], e};
            e_nxt  = ac[W-1];
            ac_ld  = 1'b1;
            e_ld   = 1'b1;
        end else if (op.do_clr) begin
            ac_nxt = '0;
            ac_ld  = 1'b1;
        end else if (op.do_inc) begin
            ac_nxt = incr[W-1:0];
            ac_ld  = 1'b1;
        end else if (op.do_ecl) begin
            e_nxt  = 1'b0;
            e_ld   = 1'b1;
        end else if (op.do_ecm) begin
            e_nxt  = ~e;
            e_ld   = 1'b1;
        end
    end

endmodule

// File: rtl/acc_regs.sv
module acc_regs #(
    parameter int W = acc_pkg::ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ac_ld,
    input  logic         e_ld,
    input  logic [W-1:0] ac_nxt,
    input  logic         e_nxt,
    output logic [W-1:0] ac_q,
    output logic         e_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else begin
            if (ac_ld) ac_q <= ac_nxt;
            if (e_ld)  e_q  <= e_nxt;
        end
    end

endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
    parameter int W = acc_pkg::ACC_W
) (
    input  logic [W-1:0] ac,
    output logic         is_zero,
    output logic         is_neg
);

    assign is_zero = ~(|ac);
    assign is_neg  = ac[W-1];

endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int W    = ACC_W,
    parameter int IN_W = CHAR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_OPS-1:0] op_sel,
    input  logic [W-1:0]     dr_in,
    input  logic [IN_W-1:0]  inp_in,
    output logic [W-1:0]     acc_out,
    output logic             e_out,
    output logic             acc_zero,
    output logic             acc_sign
);

    acc_op_t      op;
    logic [W-1:0] ac_nxt;
    logic         e_nxt;
    logic         ac_ld;
    logic         e_ld;

    assign op = decode_op(op_sel);

    acc_alu #(.W(W), .IN_W(IN_W)) alu_i (
        .op     (op),
        .ac     (acc_out),
        .e      (e_out),
        .dr     (dr_in),
        .inp    (inp_in),
        .ac_nxt (ac_nxt),
        .e_nxt  (e_nxt),
        .ac_ld  (ac_ld),
        .e_ld   (e_ld)
    );

    acc_regs #(.W(W)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .ac_ld  (ac_ld),
        .e_ld   (e_ld),
        .ac_nxt (ac_nxt),
        .e_nxt  (e_nxt),
        .ac_q   (acc_out),
        .e_q    (e_out)
    );

    acc_flags #(.W(W)) flags_i (
        .ac      (acc_out),
        .is_zero (acc_zero),
        .is_neg  (acc_sign)
    );

endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk
    import acc_pkg::*;
#(
    parameter int W    = ACC_W,
    parameter int IN_W = CHAR_W
) (
    input logic             clk,
    input logic             rst,
    input logic [N_OPS-1:0] op_sel,
    input logic [W-1:0]     dr_in,
    input logic [IN_W-1:0]  inp_in,
    input logic [W-1:0]     acc_out,
    input logic             e_out,
    input logic             acc_zero,
    input logic             acc_sign
);

    a_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(op_sel));

    a_r2_and: assert property (@(posedge clk) disable iff (rst)
        op_sel[OP_AND] |=> acc_out == ($past(acc_out) & $past(dr_in)));

    a_r3_add_carry: assert property (@(posedge clk) disable iff (rst)
        op_sel[OP_ADD] |=>
            {e_out, acc_out} == ({1'b0, $past(acc_out)} + {1'b0, $past(dr_in)}));

    a_r5_low_byte: assert property (@(posedge clk) disable iff (rst)
        op_sel[OP_INP] |=> acc_out[IN_W-1:0] == $past(inp_in)
            && acc_out[W-1:IN_W] == $past(acc_out[W-1:IN_W]));

    a_r8_rot_right: assert property (@(posedge clk) disable iff (rst)
        op_sel[OP_SHR] |=> {acc_out, e_out} == {$past(e_out), $past(acc_out)});

    a_r9_rot_left: assert property (@(posedge clk) disable iff (rst)
        op_sel[OP_SHL] |=> {e_out, acc_out} == {$past(acc_out), $past(e_out)});

    a_r10_e_only: assert property (@(posedge clk) disable iff (rst)
        (op_sel[OP_ECL] || op_sel[OP_ECM]) |=> $stable(acc_out));

    a_r7_e_kept: assert property (@(posedge clk) disable iff (rst)
        !(op_sel[OP_ADD] || op_sel[OP_SHR] || op_sel[OP_SHL]
          || op_sel[OP_ECL] || op_sel[OP_ECM]) |=> $stable(e_out));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        op_sel == '0 |=> $stable(acc_out) && $stable(e_out));

    a_r12_flags: assert property (@(posedge clk) disable iff (rst)
        acc_zero == (acc_out == '0) && acc_sign == acc_out[W-1]);

endmodule

bind acc_unit acc_unit_chk #(.W(W), .IN_W(IN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_sel   (op_sel),
    .dr_in    (dr_in),
    .inp_in   (inp_in),
    .acc_out  (acc_out),
    .e_out    (e_out),
    .acc_zero (acc_zero),
    .acc_sign (acc_sign)
);

// File: tb/acc_unit_tb_top.sv
module acc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] op_sel = '0;
    logic [15:0] dr_in = '0;
    logic [7:0]  inp_in = '0;
    logic [15:0] acc_out;
    logic        e_out;
    logic        acc_zero;
    logic        acc_sign;

    int   n_checks = 0;
    int   n_errors = 0;
    logic [15:0] ac_m = '0;
    logic        e_m = 1'b0;
    bit   finished = 0;

    always #2.5 clk = ~clk;

    acc_unit dut_i (
        .clk(clk), .rst(rst), .op_sel(op_sel), .dr_in(dr_in), .inp_in(inp_in),
        .acc_out(acc_out), .e_out(e_out), .acc_zero(acc_zero), .acc_sign(acc_sign)
    );

    function automatic string req_of(input int idx);
        case (idx)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 7: return "R6";
            5: return "R8";
            6: return "R9";
            8: return "R7";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [16:0] model(input int idx, input logic [15:0] a,
                                          input logic e, input logic [15:0] d,
                                          input logic [7:0] c);
        logic [16:0] s;
        case (idx)
            0: return {e, a & d};
            1: begin s = {1'b0, a} + {1'b0, d}; return s; end
            2: return {e, d};
            3: return {e, a[15:8], c};
            4: return {e, ~a};
            5: return {a[0], e, a[15:1]};
            6: return {a[15], a[14:0], e};
            7: return {e, 16'h0000};
            8: return {e, a + 16'h0001};
            9: return {1'b0, a};
            10: return {~e, a};
            default: return {e, a};
        endcase
    endfunction

    task automatic check(input string req);
        n_checks++;
        if (acc_out !== ac_m || e_out !== e_m) begin
            n_errors++;
            $display("FAIL %s: acc=%h e=%b expected acc=%h e=%b", req, acc_out, e_out, ac_m, e_m);
        end
        n_checks++;
        if (acc_zero !== (ac_m == 16'h0) || acc_sign !== ac_m[15]) begin
            n_errors++;
            $display("FAIL R12: zero=%b sign=%b expected zero=%b sign=%b",
                     acc_zero, acc_sign, ac_m == 16'h0, ac_m[15]);
        end
    endtask

    task automatic apply(input int idx, input logic [15:0] d, input logic [7:0] c);
        logic [16:0] r;
        @(negedge clk);
        op_sel = (idx < 11) ? (11'd1 << idx) : 11'd0;
        dr_in  = d;
        inp_in = c;
        r = model(idx, ac_m, e_m, d, c);
        {e_m, ac_m} = r;
        @(negedge clk);
        op_sel = '0;
        dr_in  = $urandom;
        check(req_of(idx));
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");
        // R3 carry out of full word, result zero
        apply(2, 16'hFFFF, 8'h00);
        apply(1, 16'h0001, 8'h00);
        // R7 increment wraps, E stays set
        apply(2, 16'hFFFF, 8'h00);
        apply(8, 16'h0000, 8'h00);
        // R5 upper byte kept
        apply(2, 16'hA5C3, 8'h00);
        apply(3, 16'h0000, 8'h7E);
        // R8 / R9 rotate chains through E
        apply(9, 16'h0, 8'h0);
        apply(2, 16'h8001, 8'h00);
        for (int i = 0; i < 17; i++) apply(5, 16'h0, 8'h0);
        for (int i = 0; i < 17; i++) apply(6, 16'h0, 8'h0);
        // R10 E ops leave AC
        apply(10, 16'h0, 8'h0);
        apply(10, 16'h0, 8'h0);
        // R6 complement and clear
        apply(4, 16'h0, 8'h0);
        apply(7, 16'h0, 8'h0);
        // R11 hold
        apply(11, 16'h1234, 8'h55);
        // R2 AND
        apply(4, 16'h0, 8'h0);
        apply(0, 16'h0F0F, 8'h0);
        for (int i = 0; i < 400; i++) begin
            apply(int'($urandom_range(0, 11)), 16'($urandom), 8'($urandom));
        end
        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ac_m = '0;
        e_m  = 1'b0;
        check("R1");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule